// File: doc/BRIEF.md
# Video Input Half-Rate Clock Phase Aligner

This block produces a clock enable that sets the internal sample rate of a digital video input port running on the pixel clock. With a 16-bit luma/chroma bus every clock carries a full sample, so the enable stays high. With an 8-bit multiplexed bus the enable is high on every other clock. Its phase is pulled into line once per video line, either from a chosen transition of the horizontal sync input or from an embedded start-of-active-video code in the byte stream.

A second output marks the clocks that carry a chroma byte, so downstream logic can split the Cb, Y, Cr, Y byte sequence. A software-visible invert bit swaps that flag. It covers links where an odd number of clocks separates the phase reset from the first chroma byte.

Top module: `vid_halfrate_aligner`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first alignment event, `pix_en` and `chroma_phase` are 0 in the half-rate modes (`mode` 1, 2 or 3).
- R2: With `mode` = 0 (16-bit bus), `pix_en` is 1 and `chroma_phase` is 0 on every clock.
- R3: With `mode` = 1 (8-bit, sync aligned), let E0 be the first rising clock edge that samples `hsync` after its selected transition. `pix_en` is 1 in the cycle after edge E0+3, 0 after E0+4, and keeps alternating from there.
- R4: The selected transition of `hsync` follows `edge_sel`/`pol_neg`. 0/0 and 1/1 select the rising transition. 1/0 and 0/1 select the falling transition.
- R5: In `mode` 1, the unselected `hsync` transition leaves the `pix_en` pattern unchanged. A later selected transition realigns it, even when that moves the phase by one clock.
- R6: With `mode` 2 or 3 (embedded codes), a byte sequence FF, 00, 00, XY in consecutive clocks with XY bit 4 = 0 makes `pix_en` 1 in the clock carrying the byte after XY. The enable then alternates.
- R7: In `mode` 2 or 3, the `hsync` input has no effect. An XY byte with bit 4 = 1, or a code sequence missing one of its bytes, does not realign.
- R8: In the half-rate modes, after alignment, `chroma_phase` equals `pix_en` when `chroma_inv` = 0 and its inverse when `chroma_inv` = 1.
- R9: In `mode` 1, an embedded start code in `vdata` does not realign the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, runs all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0: 16-bit bus, 1: 8-bit with sync alignment, 2/3: 8-bit with embedded codes |
| hsync | input | 1 | Horizontal sync line |
| edge_sel | input | 1 | 0 selects the front sync edge, 1 the rear edge |
| pol_neg | input | 1 | 1 when the sync pulse is active low |
| chroma_inv | input | 1 | Swaps the chroma/luma flag phase |
| vdata | input | DW | Video byte stream |
| pix_en | output | 1 | Internal sample-rate enable |
| chroma_phase | output | 1 | High on clocks carrying a chroma byte |

## Verification
A selected sync transition driven after a falling clock edge is sampled at the next rising edge E0. The first enabled clock follows edge E0+3, so the bench expects it four clock edges after the drive. An XY byte driven after a falling edge is sampled at the next rising edge, and the enable is due in the clock that follows that edge. The bench holds a list of the drive indices of the events that should realign, and derives the expected level on every clock from the most recent event that has matured. It compares the outputs at each falling edge, half a period clear of the edge that updates them.

// File: rtl/vid_halfrate_aligner.sv
module vid_halfrate_aligner #(
  parameter int DW       = 8,
  parameter int SYNC_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          hsync,
  input  logic          edge_sel,
  input  logic          pol_neg,
  input  logic          chroma_inv,
  input  logic [DW-1:0] vdata,
  output logic          pix_en,
  output logic          chroma_phase
);
  localparam int DLY_W = $clog2(SYNC_DLY + 1);
  localparam logic [1:0] M_WIDE = 2'd0;
  localparam logic [1:0] M_BYTE = 2'd1;
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SYNC_DLY);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(1);

  logic          hs_q, hs_p;
  logic [DLY_W-1:0] dly;
  logic [DW-1:0] b1, b2, b3;
  logic          ph, armed;

  wire wide_mode = (mode == M_WIDE);
  wire byte_mode = (mode == M_BYTE);
  wire emb_mode  = mode[1];

  wire hs_rise   = hs_q & ~hs_p;
  wire hs_fall   = ~hs_q & hs_p;
  wire want_rise = ~(edge_sel ^ pol_neg);
  wire sync_edge = want_rise ? hs_rise : hs_fall;

  wire sync_fire = byte_mode && (dly == DLY_LAST);
  wire sav_hit   = emb_mode && (b3 == {DW{1'b1}}) && (b2 == '0) && (b1 == '0) && !vdata[4];
  wire align     = sync_fire | sav_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      hs_p  <= 1'b0;
      dly   <= '0;
      b1    <= '0;
      b2    <= '0;
      b3    <= '0;
      ph    <= 1'b0;
      armed <= 1'b0;
    end else begin
      hs_q <= hsync;
      hs_p <= hs_q;
      b1   <= vdata;
      b2   <= b1;
      b3   <= b2;
      if (!byte_mode)
        dly <= '0;
      else if (sync_edge)
        dly <= DLY_LOAD;
      else if (dly != '0)
        dly <= dly - DLY_LAST;
      ph    <= align ? 1'b1 : ~ph;
      armed <= armed | align;
    end
  end

  assign pix_en       = wide_mode | (armed & ph);
  assign chroma_phase = ~wide_mode & armed & (ph ^ chroma_inv);
endmodule

// File: rtl/vid_halfrate_aligner_chk.sv
module vid_halfrate_aligner_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          chroma_inv,
  input logic [DW-1:0] vdata,
  input logic          pix_en,
  input logic          chroma_phase
);
  logic [DW-1:0] c1, c2, c3;
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1 <= '0; c2 <= '0; c3 <= '0;
    end else begin
      c1 <= vdata; c2 <= c1; c3 <= c2;
    end
  end

  wire code_seen = mode[1] && (c3 == {DW{1'b1}}) && (c2 == '0) && (c1 == '0) && !vdata[4];

  always @(posedge clk) begin
    if (rst_q && mode != 2'd0)
      assert_quiet_after_reset_R1: assert (!pix_en && !chroma_phase);
    rst_q <= !rst_n;
  end

  assert_wide_always_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (pix_en && !chroma_phase));

  assert_code_aligns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_seen |=> pix_en);

  assert_chroma_tracks_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && pix_en) |-> (chroma_phase == !chroma_inv));
endmodule

bind vid_halfrate_aligner vid_halfrate_aligner_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .chroma_inv(chroma_inv),
  .vdata(vdata), .pix_en(pix_en), .chroma_phase(chroma_phase)
);

// File: tb/vid_halfrate_aligner_tb.sv
module vid_halfrate_aligner_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic hsync = 1'b0, edge_sel = 1'b0, pol_neg = 1'b0, chroma_inv = 1'b0;
  logic [7:0] vdata = 8'h10;
  logic pix_en, chroma_phase;
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_halfrate_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hsync(hsync), .edge_sel(edge_sel),
    .pol_neg(pol_neg), .chroma_inv(chroma_inv), .vdata(vdata),
    .pix_en(pix_en), .chroma_phase(chroma_phase)
  );

  task automatic chk(input string tag, input bit en_exp, input bit ch_exp);
    compared++;
    if (pix_en !== en_exp || chroma_phase !== ch_exp) begin
      mismatched++;
      $display("FAIL %s t=%0t: pix_en=%b chroma_phase=%b expected %b %b",
               tag, $time, pix_en, chroma_phase, en_exp, ch_exp);
    end
  endtask

  function automatic bit model_en(int i, int k1, int k2, int lat);
    int k = -1;
    if (k1 >= 0 && k1 + lat <= i) k = k1;
    if (k2 >= 0 && k2 + lat <= i) k = k2;
    if (k < 0) return 1'b0;
    return ((i - k - lat) % 2) == 0;
  endfunction

  function automatic bit model_armed(int i, int k1, int lat);
    return (k1 + lat <= i);
  endfunction

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; hsync = 1'b0; vdata = 8'h10;
    @(negedge clk);
    @(negedge clk);
    chk("R1 in reset", m == 2'd0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic run_byte(input bit es, input bit pn, input bit inv);
    bit rise_sel = ~(es ^ pn);
    int k1 = rise_sel ? 5 : 18;
    int k2 = rise_sel ? 32 : 45;
    edge_sel = es; pol_neg = pn; chroma_inv = inv;
    do_reset(2'd1);
    for (int i = 1; i <= 70; i++) begin
      @(negedge clk);
      begin
        bit e = model_en(i, k1, k2, 4);
        bit a = model_armed(i, k1, 4);
        string tag = !a ? "R1 pre-align" : (i >= 60 ? "R9 code ignored" :
                     (i >= k2 + 4 ? "R5 realign" : "R3/R4 sync phase"));
        chk(tag, e, a & (e ^ inv));
        if (inv) chk("R8 inverted chroma", e, a & ~e);
      end
      if (i == 5 || i == 32) hsync = 1'b1;
      if (i == 18 || i == 45) hsync = 1'b0;
      case (i)
        56: vdata = 8'hFF;
        57, 58: vdata = 8'h00;
        59: vdata = 8'h80;
        default: vdata = 8'h10;
      endcase
    end
  endtask

  task automatic run_emb(input logic [1:0] m, input bit inv);
    chroma_inv = inv; edge_sel = 1'b0; pol_neg = 1'b0;
    do_reset(m);
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      begin
        bit e = model_en(i, 13, 48, 1);
        bit a = model_armed(i, 13, 1);
        string tag = !a ? "R1 pre-code" : (i >= 49 ? "R6 realign" :
                     (i >= 27 ? "R7 no false align" : "R6 code phase"));
        chk(tag, e, a & (e ^ inv));
      end
      if (i % 3 == 0) hsync = ~hsync;
      case (i)
        10, 23, 34, 45: vdata = 8'hFF;
        11, 12, 24, 25, 35, 46, 47: vdata = 8'h00;
        13: vdata = 8'h80;
        26: vdata = 8'h9D;
        36: vdata = 8'h80;
        48: vdata = 8'hAB;
        default: vdata = 8'h10;
      endcase
    end
  endtask

  task automatic run_wide();
    do_reset(2'd0);
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      chk("R2 full rate", 1'b1, 1'b0);
      hsync = i[1];
      chroma_inv = i[2];
      vdata = (i % 4 == 0) ? 8'hFF : 8'h00;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) run_byte(c[0], c[1], c[2]);
    run_emb(2'd2, 1'b0);
    run_emb(2'd2, 1'b1);
    run_emb(2'd3, 1'b0);
    run_wide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule